// File: doc/BRIEF.md
# Load-Linked Reservation Monitor

This block keeps the atomic-sequence reservation for one processor context. A load-linked access records its physical address, rounded down to a 16-byte boundary, and raises a reservation flag. A later store-conditional is checked against that reservation. The block reports pass or fail, a two-bit result code, and whether the store may be sent to memory. Remote writes and invalidations arrive on a snoop port. A snoop cancels the reservation when it falls in the same cache block, and the cache-block size is a parameter of its own.

Store-conditionals marked uncacheable skip the check and return a distinct code. The block counts consecutive failed store-conditionals and raises a one-cycle livelock warning each time that count reaches a multiple of a configurable period. A global-clear input produces a one-cycle wakeup for the owning thread.

Every result is registered. All outputs change at the clock edge that samples the request.

Top module: `llsc_monitor`

## Requirements
- R1: A load-linked request makes `rsv_valid` 1 and `rsv_addr` equal to `ll_addr` with bits [3:0] zeroed, from the next edge. Load-linked is applied last, after any store-conditional in the same cycle.
- R2: A cacheable store-conditional while the flag is clear returns `sc_pass`=0, `sc_issue`=0 and `sc_code`=0. `sc_done` pulses on the next edge. When `sc_done` is 0, `sc_pass`, `sc_issue` and `sc_code` are 0.
- R3: A cacheable store-conditional fails with code 0 and clears the flag when `sc_addr` with bits [3:0] zeroed differs from `rsv_addr`. A difference only in bits [3:0] still matches.
- R4: A passing cacheable store-conditional returns `sc_pass`=1, `sc_issue`=1 and `sc_code`=1, and it clears the flag.
- R5: An uncacheable store-conditional returns `sc_pass`=1, `sc_issue`=1 and `sc_code`=2. It leaves the flag and the failure count unchanged.
- R6: A snoop while the flag is clear changes neither `rsv_valid` nor `rsv_addr`.
- R7: While the flag is set, a snoop clears it only when `snp_addr` and `rsv_addr` agree above bit BLOCK_OFS_W-1. Otherwise the reservation is kept.
- R8: A snoop and a store-conditional in the same cycle: the snoop is applied first. A hitting snoop makes that store-conditional fail.
- R9: Each failed cacheable store-conditional adds 1 to `fail_count`, which saturates at its maximum. A passing cacheable store-conditional or a load-linked request returns it to 0.
- R10: `livelock_warn` pulses together with `sc_done` when a failure brings the consecutive count to a multiple of WARN_PERIOD. It stays 0 when a load-linked request arrives in the same cycle.
- R11: `gclr` makes `wake` 1 for exactly the following cycle.
- R12: After reset `rsv_valid`, `rsv_addr`, `fail_count`, `sc_done`, `livelock_warn` and `wake` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ll_valid | input | 1 | Load-linked request |
| ll_addr | input | ADDR_W | Load-linked physical address |
| sc_valid | input | 1 | Store-conditional request |
| sc_addr | input | ADDR_W | Store-conditional physical address |
| sc_uncached | input | 1 | Store-conditional is uncacheable |
| snp_valid | input | 1 | Snooped remote write or invalidation |
| snp_addr | input | ADDR_W | Snoop address |
| gclr | input | 1 | Global-clear event |
| sc_done | output | 1 | Store-conditional result valid |
| sc_pass | output | 1 | Store-conditional succeeded |
| sc_issue | output | 1 | Store may be sent to memory |
| sc_code | output | 2 | Result code: 0 fail, 1 pass, 2 uncacheable |
| rsv_valid | output | 1 | Reservation flag |
| rsv_addr | output | ADDR_W | Reserved address, 16-byte aligned |
| fail_count | output | CNT_W | Consecutive failure count |
| livelock_warn | output | 1 | Livelock warning pulse |
| wake | output | 1 | Wakeup for the owning thread |

## Verification
The bench builds the block with ADDR_W=32, BLOCK_OFS_W=6, CNT_W=8 and WARN_PERIOD=5. A period of 5 lets the warning pulse be hit twice within ten failures instead of after a hundred thousand. The 64-byte block is wider than the 16-byte reservation granule. Random addresses are drawn from a few neighbouring granules in two adjacent blocks, so snoops that hit the block but not the granule, and store-conditionals that miss by one granule, come up often.

// File: rtl/llsc_pkg.sv
`timescale 1ns/1ps
package llsc_pkg;

    typedef enum logic [1:0] {
        SC_CODE_FAIL   = 2'd0,
        SC_CODE_OK     = 2'd1,
        SC_CODE_BYPASS = 2'd2
    } sc_code_e;

endpackage

// File: rtl/llsc_rsv_check.sv
`timescale 1ns/1ps
module llsc_rsv_check #(
    parameter int ADDR_W      = 32,
    parameter int RSV_OFS_W   = 4,
    parameter int BLOCK_OFS_W = 6
) (
    input  logic              rsv_valid,
    input  logic [ADDR_W-1:0] rsv_addr,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [ADDR_W-1:0] sc_addr,
    input  logic [ADDR_W-1:0] ll_addr,
    output logic              snoop_hit,
    output logic              sc_match,
    output logic [ADDR_W-1:0] ll_base
);
    localparam logic [ADDR_W-1:0] RSV_MASK = {ADDR_W{1'b1}} << RSV_OFS_W;
    localparam logic [ADDR_W-1:0] BLK_MASK = {ADDR_W{1'b1}} << BLOCK_OFS_W;

    always_comb begin
        snoop_hit = rsv_valid && snp_valid &&
                    ((rsv_addr & BLK_MASK) == (snp_addr & BLK_MASK));
        sc_match  = ((sc_addr & RSV_MASK) == rsv_addr);
        ll_base   = ll_addr & RSV_MASK;
    end
endmodule

// File: rtl/llsc_fail_tracker.sv
`timescale 1ns/1ps
module llsc_fail_tracker #(
    parameter int CNT_W       = 24,
    parameter int WARN_PERIOD = 100000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fail_evt,
    input  logic             clear_evt,
    output logic [CNT_W-1:0] count,
    output logic             warn
);
    localparam int PER_W = (WARN_PERIOD > 1) ? $clog2(WARN_PERIOD) : 1;
    localparam logic [PER_W-1:0] PER_LAST = PER_W'(WARN_PERIOD - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [PER_W-1:0] per;
        logic             warn;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d      = trk_q;
        trk_d.warn = 1'b0;
        if (clear_evt) begin
            trk_d.cnt = '0;
            trk_d.per = '0;
        end else if (fail_evt) begin
            if (trk_q.cnt != CNT_MAX) begin
                trk_d.cnt = trk_q.cnt + 1'b1;
            end
            if (trk_q.per == PER_LAST) begin
                trk_d.per  = '0;
                trk_d.warn = 1'b1;
            end else begin
                trk_d.per = trk_q.per + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign count = trk_q.cnt;
    assign warn  = trk_q.warn;
endmodule

// File: rtl/llsc_monitor.sv
`timescale 1ns/1ps
module llsc_monitor #(
    parameter int ADDR_W      = 32,
    parameter int BLOCK_OFS_W = 6,
    parameter int CNT_W       = 24,
    parameter int WARN_PERIOD = 100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ll_valid,
    input  logic [ADDR_W-1:0] ll_addr,
    input  logic              sc_valid,
    input  logic [ADDR_W-1:0] sc_addr,
    input  logic              sc_uncached,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              gclr,
    output logic              sc_done,
    output logic              sc_pass,
    output logic              sc_issue,
    output logic [1:0]        sc_code,
    output logic              rsv_valid,
    output logic [ADDR_W-1:0] rsv_addr,
    output logic [CNT_W-1:0]  fail_count,
    output logic              livelock_warn,
    output logic              wake
);
    import llsc_pkg::*;

    localparam int RSV_OFS_W = 4;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic              done;
        logic              pass;
        logic              issue;
        sc_code_e          code;
        logic              wake;
    } mon_t;

    mon_t mon_d, mon_q;

    logic              snoop_hit;
    logic              sc_match;
    logic [ADDR_W-1:0] ll_base;
    logic              fail_evt;
    logic              clear_evt;

    llsc_rsv_check #(
        .ADDR_W      (ADDR_W),
        .RSV_OFS_W   (RSV_OFS_W),
        .BLOCK_OFS_W (BLOCK_OFS_W)
    ) rsv_chk_i (
        .rsv_valid (mon_q.valid),
        .rsv_addr  (mon_q.addr),
        .snp_valid (snp_valid),
        .snp_addr  (snp_addr),
        .sc_addr   (sc_addr),
        .ll_addr   (ll_addr),
        .snoop_hit (snoop_hit),
        .sc_match  (sc_match),
        .ll_base   (ll_base)
    );

    always_comb begin
        logic flag_post;
        logic sc_ok;
        flag_post = mon_q.valid && !snoop_hit;
        sc_ok     = sc_valid && !sc_uncached && flag_post && sc_match;

        mon_d       = mon_q;
        mon_d.valid = flag_post;
        mon_d.done  = sc_valid;
        mon_d.pass  = 1'b0;
        mon_d.issue = 1'b0;
        mon_d.code  = SC_CODE_FAIL;
        mon_d.wake  = gclr;
        fail_evt    = 1'b0;

        if (sc_valid) begin
            if (sc_uncached) begin
                mon_d.pass  = 1'b1;
                mon_d.issue = 1'b1;
                mon_d.code  = SC_CODE_BYPASS;
            end else if (sc_ok) begin
                mon_d.pass  = 1'b1;
                mon_d.issue = 1'b1;
                mon_d.code  = SC_CODE_OK;
                mon_d.valid = 1'b0;
            end else begin
                mon_d.valid = 1'b0;
                fail_evt    = 1'b1;
            end
        end

        if (ll_valid) begin
            mon_d.valid = 1'b1;
            mon_d.addr  = ll_base;
        end

        clear_evt = ll_valid || sc_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mon_q <= '0;
        end else begin
            mon_q <= mon_d;
        end
    end

    llsc_fail_tracker #(
        .CNT_W       (CNT_W),
        .WARN_PERIOD (WARN_PERIOD)
    ) fail_trk_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .fail_evt  (fail_evt),
        .clear_evt (clear_evt),
        .count     (fail_count),
        .warn      (livelock_warn)
    );

    assign sc_done   = mon_q.done;
    assign sc_pass   = mon_q.pass;
    assign sc_issue  = mon_q.issue;
    assign sc_code   = mon_q.code;
    assign rsv_valid = mon_q.valid;
    assign rsv_addr  = mon_q.addr;
    assign wake      = mon_q.wake;
endmodule

// File: rtl/llsc_monitor_chk.sv
`timescale 1ns/1ps
module llsc_monitor_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ll_valid,
    input logic              gclr,
    input logic              sc_done,
    input logic              sc_pass,
    input logic              sc_issue,
    input logic [1:0]        sc_code,
    input logic              rsv_valid,
    input logic [ADDR_W-1:0] rsv_addr,
    input logic [CNT_W-1:0]  fail_count,
    input logic              livelock_warn,
    input logic              wake
);
    assert_ll_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ll_valid |=> (rsv_valid && rsv_addr[3:0] == 4'd0));

    assert_fail_no_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_done && !sc_pass) |-> (sc_code == 2'd0 && !sc_issue));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sc_done |-> (!sc_pass && !sc_issue && sc_code == 2'd0));

    assert_pass_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_done && sc_code == 2'd1 && !$past(ll_valid)) |-> !rsv_valid);

    assert_bypass_issues_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_done && sc_code == 2'd2) |-> (sc_issue && sc_pass));

    assert_fail_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_done && !sc_pass && !$past(ll_valid) && $past(fail_count) != {CNT_W{1'b1}})
        |-> (fail_count == $past(fail_count) + 1'b1));

    assert_warn_on_fail_R10: assert property (@(posedge clk) disable iff (!rst_n)
        livelock_warn |-> (sc_done && !sc_pass));

    assert_wake_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        gclr |=> wake);

    assert_wake_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> $past(gclr));
endmodule

bind llsc_monitor llsc_monitor_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .ll_valid      (ll_valid),
    .gclr          (gclr),
    .sc_done       (sc_done),
    .sc_pass       (sc_pass),
    .sc_issue      (sc_issue),
    .sc_code       (sc_code),
    .rsv_valid     (rsv_valid),
    .rsv_addr      (rsv_addr),
    .fail_count    (fail_count),
    .livelock_warn (livelock_warn),
    .wake          (wake)
);

// File: tb/llsc_monitor_tb.sv
`timescale 1ns/1ps
module llsc_monitor_tb_top;
    localparam int AW   = 32;
    localparam int BOFS = 6;
    localparam int CW   = 8;
    localparam int PER  = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ll_valid = 1'b0, sc_valid = 1'b0, sc_uncached = 1'b0;
    logic          snp_valid = 1'b0, gclr = 1'b0;
    logic [AW-1:0] ll_addr = '0, sc_addr = '0, snp_addr = '0;
    logic          sc_done, sc_pass, sc_issue, rsv_valid, livelock_warn, wake;
    logic [1:0]    sc_code;
    logic [AW-1:0] rsv_addr;
    logic [CW-1:0] fail_count;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    logic          m_valid = 1'b0;
    logic [AW-1:0] m_addr  = '0;
    int            m_fail  = 0;
    int            m_per   = 0;

    always #5 clk = ~clk;

    llsc_monitor #(
        .ADDR_W      (AW),
        .BLOCK_OFS_W (BOFS),
        .CNT_W       (CW),
        .WARN_PERIOD (PER)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .ll_valid(ll_valid), .ll_addr(ll_addr),
        .sc_valid(sc_valid), .sc_addr(sc_addr), .sc_uncached(sc_uncached),
        .snp_valid(snp_valid), .snp_addr(snp_addr), .gclr(gclr),
        .sc_done(sc_done), .sc_pass(sc_pass), .sc_issue(sc_issue), .sc_code(sc_code),
        .rsv_valid(rsv_valid), .rsv_addr(rsv_addr), .fail_count(fail_count),
        .livelock_warn(livelock_warn), .wake(wake)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic string pick(input string ovr, input string dflt);
        return (ovr != "") ? ovr : dflt;
    endfunction

    // Drives one cycle of stimulus at a falling edge and checks at the next one.
    task automatic step(input logic ll, input logic [AW-1:0] lla,
                        input logic sc, input logic [AW-1:0] sca, input logic unc,
                        input logic snp, input logic [AW-1:0] snpa,
                        input logic gc, input string ovr);
        logic       f1, hit, e_pass, e_issue, e_warn;
        logic [1:0] e_code;
        string      t_sc, t_rsv;
        ll_valid = ll; ll_addr = lla; sc_valid = sc; sc_addr = sca;
        sc_uncached = unc; snp_valid = snp; snp_addr = snpa; gclr = gc;

        hit = m_valid && snp && ((snpa >> BOFS) == (m_addr >> BOFS));
        f1  = m_valid && !hit;
        t_rsv = hit ? "R7" : (snp ? "R6" : "R1");
        e_pass = 1'b0; e_issue = 1'b0; e_code = 2'd0; e_warn = 1'b0; t_sc = "R2";
        if (sc) begin
            if (unc) begin
                e_pass = 1'b1; e_issue = 1'b1; e_code = 2'd2; t_sc = "R5";
            end else if (f1 && ((sca & ~32'hf) == m_addr)) begin
                e_pass = 1'b1; e_issue = 1'b1; e_code = 2'd1; t_sc = "R4";
                f1 = 1'b0; m_fail = 0; m_per = 0;
            end else begin
                t_sc = hit ? "R8" : (m_valid ? "R3" : "R2");
                f1 = 1'b0;
                if (!ll) begin
                    if (m_fail != (1 << CW) - 1) m_fail++;
                    if (m_per == PER - 1) begin
                        m_per = 0; e_warn = 1'b1;
                    end else begin
                        m_per++;
                    end
                end
            end
        end
        if (ll) begin
            m_addr = lla & ~32'hf; f1 = 1'b1; m_fail = 0; m_per = 0; t_rsv = "R1";
        end
        m_valid = f1;

        @(negedge clk);
        chk(pick(ovr, t_sc), "sc_done", 64'(sc_done), 64'(sc));
        chk(pick(ovr, t_sc), "sc_pass", 64'(sc_pass), 64'(e_pass));
        chk(pick(ovr, t_sc), "sc_issue", 64'(sc_issue), 64'(e_issue));
        chk(pick(ovr, t_sc), "sc_code", 64'(sc_code), 64'(e_code));
        chk(pick(ovr, t_rsv), "rsv_valid", 64'(rsv_valid), 64'(m_valid));
        chk(pick(ovr, t_rsv), "rsv_addr", 64'(rsv_addr), 64'(m_addr));
        chk(pick(ovr, "R9"), "fail_count", 64'(fail_count), 64'(m_fail));
        chk(pick(ovr, "R10"), "livelock_warn", 64'(livelock_warn), 64'(e_warn));
        chk(pick(ovr, "R11"), "wake", 64'(wake), 64'(gc));
    endtask

    task automatic idle(input string ovr);
        step(1'b0, '0, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0, ovr);
    endtask

    function automatic logic [AW-1:0] rnd_addr();
        return 32'h1200 + 32'(($urandom % 4) * 16) + 32'($urandom % 16)
               + 32'(($urandom % 2) * 64);
    endfunction

    initial begin
        #2_000_000;
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12", "rsv_valid", 64'(rsv_valid), 64'd0);
        chk("R12", "rsv_addr", 64'(rsv_addr), 64'd0);
        chk("R12", "fail_count", 64'(fail_count), 64'd0);
        chk("R12", "sc_done", 64'(sc_done), 64'd0);
        chk("R12", "livelock_warn", 64'(livelock_warn), 64'd0);
        chk("R12", "wake", 64'(wake), 64'd0);
        rst_n = 1'b1;
        idle("R12");

        // R2: store-conditional with no reservation
        step(1'b0, '0, 1'b1, 32'h1230, 1'b0, 1'b0, '0, 1'b0, "R2");
        // R6: snoop with the flag clear
        step(1'b0, '0, 1'b0, '0, 1'b0, 1'b1, 32'h0000, 1'b0, "R6");
        // R1: load-linked aligns down to 16 bytes
        step(1'b1, 32'h1237, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0, "R1");
        // R3 and R4: low-bit difference still passes, then the reservation is spent
        step(1'b0, '0, 1'b1, 32'h123c, 1'b0, 1'b0, '0, 1'b0, "R4");
        step(1'b0, '0, 1'b1, 32'h1230, 1'b0, 1'b0, '0, 1'b0, "R4");
        // R3: one granule away
        step(1'b1, 32'h1230, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0, "R9");
        step(1'b0, '0, 1'b1, 32'h1240, 1'b0, 1'b0, '0, 1'b0, "R3");
        // R7: snoop outside the block keeps, inside clears
        step(1'b1, 32'h1230, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0, "R1");
        step(1'b0, '0, 1'b0, '0, 1'b0, 1'b1, 32'h1270, 1'b0, "R7");
        step(1'b0, '0, 1'b0, '0, 1'b0, 1'b1, 32'h1208, 1'b0, "R7");
        // R5: uncacheable bypass keeps flag and count
        step(1'b0, '0, 1'b1, 32'h9990, 1'b0, 1'b0, '0, 1'b0, "R5");
        step(1'b1, 32'h1230, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0, "R5");
        step(1'b0, '0, 1'b1, 32'h9990, 1'b1, 1'b0, '0, 1'b0, "R5");
        // R8: snoop and store-conditional together
        step(1'b0, '0, 1'b1, 32'h1230, 1'b0, 1'b1, 32'h1220, 1'b0, "R8");
        // R11: wakeup pulse lasts one cycle
        step(1'b0, '0, 1'b0, '0, 1'b0, 1'b0, '0, 1'b1, "R11");
        idle("R11");
        // R10: warnings at the 5th and 10th consecutive failure
        step(1'b1, 32'h5000, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0, "R10");
        for (int i = 0; i < 11; i++) begin
            step(1'b0, '0, 1'b1, 32'h6000, 1'b0, 1'b0, '0, 1'b0, "R10");
        end
        // R9: passing store-conditional resets the count
        step(1'b1, 32'h5000, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0, "R9");
        step(1'b0, '0, 1'b1, 32'h5004, 1'b0, 1'b0, '0, 1'b0, "R9");

        // constrained random traffic
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 4) == 0, rnd_addr(),
                 ($urandom % 3) == 0, rnd_addr(), ($urandom % 8) == 0,
                 ($urandom % 4) == 0, rnd_addr(),
                 ($urandom % 10) == 0, "");
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule